// File: doc/BRIEF.md
# Instruction cache line refiller

This block fills a single instruction-cache line from a simple read-only memory bus. The cache starts a refill by handing over the byte address of the line's first byte. The refiller then walks through the line one fetch block at a time, in increasing address order. Each fetch block is built from one or more bus words. Every finished block goes back to the cache as a beat on a valid/ready output channel. A beat carries the block data, the block's physical byte address, an error flag and a last flag.

The bus side handles one read at a time. A request carries a word address, formed by shifting the byte address right by log2 of the bus word size in bytes, and it enables every byte lane. The response is a single-cycle pulse carrying a data word and an error flag. The bus has no response back-pressure.

On the beat channel the cache may hold `beat_ready` low for as long as it likes. While it does, the beat stays put with every field unchanged. A beat is consumed on a cycle where both `beat_valid` and `beat_ready` are high.

The first bus error ends the transfer. The beat that contains the failing word is offered at once, with error and last both set. After a beat with last set has been consumed, the channel stays quiet until a new start is accepted. New starts are refused with `start_ready` low for the whole of a transfer.

Top module: `icache_line_refiller`

## Requirements
- R1: `start_ready` is high only while the refiller is idle. A start offered during a transfer is not taken and does not change the line being fetched.
- R2: Beats are produced in increasing address order. Beat k carries `beat_addr` = line base + k × (fetch-block bytes). The line base is the start address with its line-offset bits cleared.
- R3: Every bus request carries `bus_req_addr` = byte address >> log2(bus word bytes), with all `bus_req_sel` bits set. Word addresses run consecutively from the line base.
- R4: When a fetch block spans several bus words, the word from the lowest address lands in bits [BUS_W-1:0], and later words fill successively higher slices (little-endian packing).
- R5: `beat_err` is the OR of the error flags of the words in that beat. When a word reports an error, no further bus reads are issued for that line, and the beat holding that word has `beat_last` set.
- R6: Without errors, `beat_last` is set only on the beat of the final fetch block in the line.
- R7: After a beat with `beat_last` set is consumed, `beat_valid` stays low and `start_ready` is high until the next start is accepted.
- R8: While `beat_valid` is high and `beat_ready` is low, `beat_valid` stays high and `beat_data`, `beat_addr`, `beat_err` and `beat_last` stay unchanged.
- R9: While reset is low, and right after it, the refiller is idle: `start_ready` high, `beat_valid` low and `bus_req_valid` low. A reset in the middle of a transfer abandons that transfer.
- R10: At most one bus read is outstanding. After a request is accepted, `bus_req_valid` stays low until its response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Refill start offered |
| start_ready | output | 1 | Refiller idle, start can be taken |
| start_addr | input | ADDR_W | Line byte address for the refill |
| bus_req_valid | output | 1 | Bus read request valid |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_addr | output | ADDR_W-log2(BUS_W/8) | Bus word address |
| bus_req_sel | output | BUS_W/8 | Byte-lane enables, all set |
| bus_rsp_valid | input | 1 | Read response pulse |
| bus_rsp_data | input | BUS_W | Read data word |
| bus_rsp_err | input | 1 | Read response error |
| beat_valid | output | 1 | Beat offered to the cache |
| beat_ready | input | 1 | Cache takes the beat |
| beat_data | output | BLK_W | Fetch block data |
| beat_addr | output | ADDR_W | Byte address of the fetch block |
| beat_err | output | 1 | Bus error in this block |
| beat_last | output | 1 | Final beat of the transfer |

## Verification
The hardest case to reach from the ports is an error on a chosen word deep inside a line, with the bus and the cache both stalling at the same time. Only that mix shows whether the refiller stops issuing reads, marks the right beat as last, and then stays quiet. The stimulus table places the failing word by its offset within the line: the first word, the second word of a middle block, the first word of the final block, and the very last word. Each entry also sets the bus-ready and beat-ready stall patterns and the response latency. Throughout every transfer the bench holds a conflicting start request asserted, so a start accepted while busy would show up as wrong beat addresses.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic [1:0] {
    RF_IDLE = 2'd0,
    RF_REQ  = 2'd1,
    RF_WAIT = 2'd2,
    RF_OUT  = 2'd3
  } rf_state_e;

  // Index width that stays at least one bit for a count of one
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int unsigned BLKS   = 4,
  parameter int unsigned WPB    = 2,
  parameter int unsigned BIDX_W = 2,
  parameter int unsigned WIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic              beat_err,
  output logic              beat_last,
  output logic [BIDX_W-1:0] blk_idx,
  output logic [WIDX_W-1:0] word_idx,
  output logic              capture
);

  localparam logic [BIDX_W-1:0] LAST_BLK  = BIDX_W'(BLKS - 1);
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WPB - 1);

  rf_state_e state_q;
  logic      err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= RF_IDLE;
      blk_idx  <= '0;
      word_idx <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        RF_IDLE: if (start_valid) begin
          state_q  <= RF_REQ;
          blk_idx  <= '0;
          word_idx <= '0;
          err_q    <= 1'b0;
        end
        RF_REQ: if (bus_req_ready) state_q <= RF_WAIT;
        RF_WAIT: if (rsp_valid) begin
          err_q <= err_q | rsp_err;
          // an erroring word closes the block and the line at once
          if (rsp_err || word_idx == LAST_WORD) begin
            state_q <= RF_OUT;
          end else begin
            word_idx <= word_idx + 1'b1;
            state_q  <= RF_REQ;
          end
        end
        RF_OUT: if (beat_ready) begin
          if (beat_last) begin
            state_q <= RF_IDLE;
          end else begin
            blk_idx  <= blk_idx + 1'b1;
            word_idx <= '0;
            err_q    <= 1'b0;
            state_q  <= RF_REQ;
          end
        end
        default: state_q <= RF_IDLE;
      endcase
    end
  end

  always_comb begin
    start_ready   = (state_q == RF_IDLE);
    bus_req_valid = (state_q == RF_REQ);
    beat_valid    = (state_q == RF_OUT);
    capture       = (state_q == RF_WAIT) && rsp_valid;
    beat_err      = err_q;
    beat_last     = err_q || (blk_idx == LAST_BLK);
  end

  // R10: no second request while a read is in flight
  a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_ready |=> !bus_req_valid);

  // R7: channel goes quiet after the final beat
  a_r7_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> !beat_valid);

  // R1: a taken start closes the start channel
  a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> !start_ready);

endmodule

// File: rtl/refill_addr_gen.sv
module refill_addr_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BUS_OFF    = 2,
  parameter int unsigned BLK_OFF    = 3,
  parameter int unsigned LINE_OFF   = 5,
  parameter int unsigned BIDX_W     = 2,
  parameter int unsigned WIDX_W     = 1,
  parameter int unsigned BUS_ADDR_W = ADDR_W - BUS_OFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic [BIDX_W-1:0]     blk_idx,
  input  logic [WIDX_W-1:0]     word_idx,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [BUS_ADDR_W-1:0] bus_req_addr
);

  localparam logic [ADDR_W-1:0] LINE_MASK = (ADDR_W'(1) << LINE_OFF) - ADDR_W'(1);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] byte_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= start_addr & ~LINE_MASK;
  end

  always_comb begin
    beat_addr    = base_q + (ADDR_W'(blk_idx) << BLK_OFF);
    byte_addr    = beat_addr + (ADDR_W'(word_idx) << BUS_OFF);
    bus_req_addr = BUS_ADDR_W'(byte_addr >> BUS_OFF);
  end

endmodule

// File: rtl/refill_pack.sv
module refill_pack #(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned WPB    = 2,
  parameter int unsigned WIDX_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic [WIDX_W-1:0]    word_idx,
  input  logic [BUS_W-1:0]     rsp_data,
  output logic [BUS_W*WPB-1:0] blk_data
);

  // one register per word slot: lowest address in the lowest slice
  for (genvar g = 0; g < WPB; g++) begin : g_slot
    logic [BUS_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (capture && word_idx == WIDX_W'(g))
        word_q <= rsp_data;
    end
    assign blk_data[g*BUS_W +: BUS_W] = word_q;
  end

endmodule

// File: rtl/icache_line_refiller.sv
module icache_line_refiller
  import refill_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned BLK_W  = 64,
  parameter int unsigned BLKS   = 4,
  localparam int unsigned BUS_OFF    = $clog2(BUS_W / 8),
  localparam int unsigned BUS_ADDR_W = ADDR_W - BUS_OFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_valid,
  output logic                  start_ready,
  input  logic [ADDR_W-1:0]     start_addr,
  output logic                  bus_req_valid,
  input  logic                  bus_req_ready,
  output logic [BUS_ADDR_W-1:0] bus_req_addr,
  output logic [BUS_W/8-1:0]    bus_req_sel,
  input  logic                  bus_rsp_valid,
  input  logic [BUS_W-1:0]      bus_rsp_data,
  input  logic                  bus_rsp_err,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [BLK_W-1:0]      beat_data,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic                  beat_err,
  output logic                  beat_last
);

  localparam int unsigned WPB      = BLK_W / BUS_W;
  localparam int unsigned BLK_OFF  = $clog2(BLK_W / 8);
  localparam int unsigned LINE_OFF = BLK_OFF + $clog2(BLKS);
  localparam int unsigned WIDX_W   = idx_w(WPB);
  localparam int unsigned BIDX_W   = idx_w(BLKS);

  logic [BIDX_W-1:0] blk_idx;
  logic [WIDX_W-1:0] word_idx;
  logic              capture;

  assign bus_req_sel = '1;

  refill_ctrl #(
    .BLKS(BLKS), .WPB(WPB), .BIDX_W(BIDX_W), .WIDX_W(WIDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .rsp_valid(bus_rsp_valid), .rsp_err(bus_rsp_err),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_err(beat_err), .beat_last(beat_last),
    .blk_idx(blk_idx), .word_idx(word_idx), .capture(capture)
  );

  refill_addr_gen #(
    .ADDR_W(ADDR_W), .BUS_OFF(BUS_OFF), .BLK_OFF(BLK_OFF), .LINE_OFF(LINE_OFF),
    .BIDX_W(BIDX_W), .WIDX_W(WIDX_W), .BUS_ADDR_W(BUS_ADDR_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(start_valid && start_ready), .start_addr(start_addr),
    .blk_idx(blk_idx), .word_idx(word_idx),
    .beat_addr(beat_addr), .bus_req_addr(bus_req_addr)
  );

  refill_pack #(
    .BUS_W(BUS_W), .WPB(WPB), .WIDX_W(WIDX_W)
  ) u_pack (
    .clk(clk), .rst_n(rst_n),
    .capture(capture), .word_idx(word_idx), .rsp_data(bus_rsp_data),
    .blk_data(beat_data)
  );

  // R8: a stalled beat holds every field
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_data) &&
    $stable(beat_addr) && $stable(beat_err) && $stable(beat_last));

  // R5: an erroring beat always ends the transfer
  a_r5_err_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_err |-> beat_last);

endmodule

// File: tb/icache_line_refiller_tb.sv
module icache_line_refiller_tb;

  typedef struct packed {
    logic [31:0] base;
    logic [3:0]  errw;    // word offset in line that fails, 15 = none
    logic        bstall;
    logic        cstall;
    logic [1:0]  lat;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{32'h0000_1000, 4'd15, 1'b0, 1'b0, 2'd0},
    '{32'h0000_2FE0, 4'd15, 1'b1, 1'b0, 2'd1},
    '{32'h8000_0040, 4'd15, 1'b0, 1'b1, 2'd0},
    '{32'h1234_5660, 4'd0,  1'b0, 1'b0, 2'd0},
    '{32'h0000_0100, 4'd3,  1'b1, 1'b1, 2'd2},
    '{32'hFFFF_FFE0, 4'd6,  1'b0, 1'b1, 2'd0},
    '{32'h0000_0020, 4'd7,  1'b1, 1'b0, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [31:0] start_addr = '0;
  logic        bus_req_valid;
  logic        bus_req_ready = 1'b0;
  logic [29:0] bus_req_addr;
  logic [3:0]  bus_req_sel;
  logic        bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_data = '0;
  logic        bus_rsp_err = 1'b0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [63:0] beat_data;
  logic [31:0] beat_addr;
  logic        beat_err;
  logic        beat_last;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 1'b0;

  logic [31:0] cur_base = '0;
  logic [3:0]  cur_errw = 4'd15;
  logic        cur_bstall = 1'b0;
  logic [1:0]  cur_lat = 2'd0;
  logic [29:0] exp_waddr = '0;
  int          req_cnt = 0;
  bit          pend = 1'b0;
  logic [29:0] paddr = '0;
  logic [1:0]  dly = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  icache_line_refiller u_dut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready), .start_addr(start_addr),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_addr(bus_req_addr), .bus_req_sel(bus_req_sel),
    .bus_rsp_valid(bus_rsp_valid), .bus_rsp_data(bus_rsp_data), .bus_rsp_err(bus_rsp_err),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_data(beat_data),
    .beat_addr(beat_addr), .beat_err(beat_err), .beat_last(beat_last)
  );

  function automatic logic [31:0] mw(input logic [29:0] wa);
    return {wa[15:0] ^ 16'h5A3C, ~wa[15:0]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // bus responder: one cycle plus cur_lat extra latency
  initial begin
    forever begin
      @(negedge clk);
      bus_rsp_valid = 1'b0;
      bus_rsp_err   = 1'b0;
      if (!rst_n) begin
        pend = 1'b0;
      end else begin
        if (pend) begin
          if (dly == 2'd0) begin
            bus_rsp_valid = 1'b1;
            bus_rsp_data  = mw(paddr);
            bus_rsp_err   = (cur_errw != 4'd15) && ((paddr - cur_base[31:2]) == 30'(cur_errw));
            pend = 1'b0;
          end else begin
            dly = dly - 2'd1;
          end
        end
        bus_req_ready = cur_bstall ? (cyc % 3 != 0) : 1'b1;
        if (bus_req_valid && bus_req_ready) begin
          chk("R10", 64'(pend), 64'(0));
          chk("R3", 64'(bus_req_addr), 64'(exp_waddr));
          chk("R3", 64'(bus_req_sel), 64'hF);
          exp_waddr = exp_waddr + 30'd1;
          req_cnt++;
          pend  = 1'b1;
          paddr = bus_req_addr;
          dly   = cur_lat;
        end
      end
    end
  end

  task automatic setup(input vec_t v);
    cur_base   = v.base;
    cur_errw   = v.errw;
    cur_bstall = v.bstall;
    cur_lat    = v.lat;
    exp_waddr  = v.base[31:2];
    req_cnt    = 0;
  endtask

  task automatic run_vec(input vec_t v);
    int nb;
    int nreq;
    int k;
    bit prev_hold;
    logic [63:0] pd;
    logic [31:0] pa;
    logic pe, pl;
    logic [29:0] wb;
    setup(v);
    nb   = (v.errw == 4'd15) ? 4 : int'(v.errw) / 2 + 1;
    nreq = (v.errw == 4'd15) ? 8 : int'(v.errw) + 1;
    wb   = v.base[31:2];
    @(negedge clk);
    start_valid = 1'b1;
    start_addr  = v.base;
    @(negedge clk);
    // conflicting start held during the transfer (R1)
    start_addr = ~v.base & 32'hFFFF_FFE0;
    k = 0;
    prev_hold = 1'b0;
    pd = '0; pa = '0; pe = 1'b0; pl = 1'b0;
    while (k < nb) begin
      chk("R1", 64'(start_ready), 64'(0));
      if (prev_hold) begin
        chk("R8", 64'(beat_valid), 64'(1));
        chk("R8", beat_data, pd);
        chk("R8", 64'(beat_addr), 64'(pa));
        chk("R8", 64'({beat_err, beat_last}), 64'({pe, pl}));
      end
      beat_ready = v.cstall ? (cyc % 2 == 0) : 1'b1;
      prev_hold = 1'b0;
      if (beat_valid) begin
        if (beat_ready) begin
          chk("R2", 64'(beat_addr), 64'(v.base + 32'(8 * k)));
          if (!beat_err)
            chk("R4", beat_data, {mw(wb + 30'(2 * k + 1)), mw(wb + 30'(2 * k))});
          chk("R5", 64'(beat_err), 64'((v.errw != 4'd15) && (int'(v.errw) / 2 == k)));
          chk("R6", 64'(beat_last), 64'(k == nb - 1));
          if (k == nb - 1) start_valid = 1'b0;
          k++;
        end else begin
          prev_hold = 1'b1;
          pd = beat_data; pa = beat_addr; pe = beat_err; pl = beat_last;
        end
      end
      @(negedge clk);
    end
    beat_ready = 1'b1;
    chk("R7", 64'(start_ready), 64'(1));
    for (int i = 0; i < 3; i++) begin
      chk("R7", 64'(beat_valid), 64'(0));
      chk("R5", 64'(bus_req_valid), 64'(0));
      @(negedge clk);
    end
    chk("R5", 64'(req_cnt), 64'(nreq));
    beat_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", 64'({start_ready, beat_valid, bus_req_valid}), 64'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", 64'({start_ready, beat_valid, bus_req_valid}), 64'(3'b100));

    for (int i = 0; i < 7; i++) run_vec(VECS[i]);

    // directed: reset in the middle of a transfer, then recover
    setup(VECS[2]);
    start_valid = 1'b1;
    start_addr  = VECS[2].base;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", 64'({start_ready, beat_valid, bus_req_valid}), 64'(3'b100));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", 64'({start_ready, beat_valid, bus_req_valid}), 64'(3'b100));
    run_vec(VECS[0]);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL WDOG act=hung exp=done");
      summary();
      $finish;
    end
  end

endmodule